// File: doc/BRIEF.md
# Narrow-Channel Burst Width Converter

This block sits on the controller side of a narrow, fast memory channel. The memory core hands over one 64-bit line per access. The transmit path breaks that line into eight bytes and drives them onto a byte-wide lane, one byte on each fast-clock beat. Each byte carries its own parity bit, and a framing strobe marks the first byte of each burst. The channel therefore runs at eight times the rate at which the core delivers lines.

The receive path takes a byte lane of the same shape and packs each group of four accepted bytes into a 32-bit word for the processor side. Each burst yields two words, which arrive at one quarter of the channel rate. A one-cycle valid pulse on each word serves as the processor-beat enable, and a select bit tells the two halves of the line apart. The framing strobe realigns the byte counter of the receiver, and a parity mismatch on any accepted byte sets a flag that stays set until reset.

The whole block runs on a single fast clock, one clock per channel beat, and uses a synchronous active-high reset.

Top module: `burst_width_conv`

## Requirements
- R1: A line is accepted on a clock edge where `tx_line_valid` and `tx_line_ready` are both high. Its bytes appear on `ch_tx_data` on the following eight cycles, one per cycle, in ascending order. Bits 7:0 come first, on the cycle right after acceptance, and bits 63:56 come last.
- R2: While `ch_tx_valid` is high, `ch_tx_par` is the even parity bit of `ch_tx_data`: the XOR of its eight bits, so that the nine bits together hold an even number of ones.
- R3: `ch_tx_valid` is high on all eight beats of a burst and low when no burst is being sent. `ch_tx_frame` is high only on the beat that carries bits 7:0.
- R4: `tx_line_ready` is high when the transmitter is idle. It goes low on the cycle after acceptance and rises again on the beat that shows the last byte, so the next line can follow without a gap. A line offered while `tx_line_ready` is low is not taken, and the current burst goes on unchanged.
- R5: The receiver stores each byte that has `ch_rx_valid` high. After the fourth byte of a group it raises `rx_word_valid` for exactly one cycle, on the cycle after that fourth byte was sampled. The first byte of the group sits in bits 7:0 of `rx_word_data` and the fourth in bits 31:24.
- R6: `rx_word_sel` is 0 for the word built from bytes 0 to 3 of a burst and 1 for the word built from bytes 4 to 7, so the low half of the line is delivered first.
- R7: A byte that has `ch_rx_frame` high is always taken as byte 0 of a new burst. Bytes gathered before it in an unfinished word are dropped and are never output.
- R8: An accepted byte whose parity bit does not match even parity sets `rx_par_err` on the next cycle. The flag then stays set until reset.
- R9: After reset, `tx_line_ready` is 1 and `ch_tx_valid`, `ch_tx_frame`, `rx_word_valid` and `rx_par_err` are 0.
- R10: While `ch_rx_valid` is low, the data, parity and frame inputs are ignored. They do not advance the byte count, do not change the word being built and do not set `rx_par_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, one cycle per channel beat |
| rst | input | 1 | Synchronous active-high reset |
| tx_line_valid | input | 1 | A core line is offered |
| tx_line_data | input | 64 | Core line to send |
| tx_line_ready | output | 1 | Transmitter can take a line |
| ch_tx_data | output | 8 | Outgoing channel byte |
| ch_tx_par | output | 1 | Even parity bit of the outgoing byte |
| ch_tx_frame | output | 1 | First beat of an outgoing burst |
| ch_tx_valid | output | 1 | Outgoing beat carries a byte |
| ch_rx_data | input | 8 | Incoming channel byte |
| ch_rx_par | input | 1 | Parity bit of the incoming byte |
| ch_rx_frame | input | 1 | First beat of an incoming burst |
| ch_rx_valid | input | 1 | Incoming beat carries a byte |
| rx_word_data | output | 32 | Assembled processor word |
| rx_word_valid | output | 1 | One-cycle pulse for a new word |
| rx_word_sel | output | 1 | 0 for the low half of the line, 1 for the high half |
| rx_par_err | output | 1 | Sticky flag for a parity mismatch |

## Verification
Byte k of an accepted line (k from 0 to 7) is due k+1 edges after the accepting edge. The bench drives a line at a falling edge, then reads one byte at each of the next eight falling edges together with its parity, frame and ready values. An assembled word, its select bit and the parity flag are due one edge after the byte that completes or breaks them. The bench keeps a model of the expected outputs that it updates whenever it drives a receive beat. It compares that model with the ports at the next falling edge, before it drives the following beat. Idle beats, beats with bad parity on an invalid cycle, and frame strobes in the middle of a word are mixed into random bursts so that each of these results falls on a known edge.

// File: rtl/bwc_pkg.sv
`timescale 1ns/1ps
package bwc_pkg;
  // Default geometry: byte lane, eight beats per core line, four beats per word
  localparam int BWC_LANE_W     = 8;
  localparam int BWC_LINE_BEATS = 8;
  localparam int BWC_WORD_BEATS = 4;

  typedef enum logic {
    TX_IDLE  = 1'b0,
    TX_BURST = 1'b1
  } tx_state_e;
endpackage

// File: rtl/bwc_serializer.sv
`timescale 1ns/1ps
module bwc_serializer
  import bwc_pkg::*;
#(
  parameter int LANE_W     = BWC_LANE_W,
  parameter int LINE_BEATS = BWC_LINE_BEATS,
  localparam int LINE_W    = LANE_W * LINE_BEATS,
  localparam int CNT_W     = $clog2(LINE_BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_valid,
  input  logic [LINE_W-1:0] line_data,
  output logic              line_ready,
  output logic [LANE_W-1:0] ch_data,
  output logic              ch_par,
  output logic              ch_frame,
  output logic              ch_valid
);
  tx_state_e         state;
  logic [CNT_W-1:0]  beat;
  logic [LINE_W-1:0] shreg;
  logic              take;

  assign line_ready = (state == TX_IDLE);
  assign take       = line_valid && line_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= TX_IDLE;
      beat     <= '0;
      shreg    <= '0;
      ch_data  <= '0;
      ch_par   <= 1'b0;
      ch_frame <= 1'b0;
      ch_valid <= 1'b0;
    end else if (take) begin
      ch_data  <= line_data[LANE_W-1:0];
      ch_par   <= ^line_data[LANE_W-1:0];
      ch_frame <= 1'b1;
      ch_valid <= 1'b1;
      shreg    <= line_data >> LANE_W;
      beat     <= CNT_W'(1);
      state    <= TX_BURST;
    end else if (state == TX_BURST) begin
      ch_data  <= shreg[LANE_W-1:0];
      ch_par   <= ^shreg[LANE_W-1:0];
      ch_frame <= 1'b0;
      ch_valid <= 1'b1;
      shreg    <= shreg >> LANE_W;
      beat     <= beat + CNT_W'(1);
      if (beat == CNT_W'(LINE_BEATS - 1)) state <= TX_IDLE;
    end else begin
      ch_frame <= 1'b0;
      ch_valid <= 1'b0;
    end
  end

  // Acceptance always closes the door for the following cycle
  assert_accept_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    take |=> !line_ready);

  // A silent lane means the transmitter is free
  assert_idle_ready_R4: assert property (@(posedge clk) disable iff (rst)
    !ch_valid |-> line_ready);

  assert_even_parity_R2: assert property (@(posedge clk) disable iff (rst)
    ch_valid |-> (ch_par == ^ch_data));

  assert_frame_in_burst_R3: assert property (@(posedge clk) disable iff (rst)
    ch_frame |-> ch_valid);

  assert_frame_single_R3: assert property (@(posedge clk) disable iff (rst)
    ch_frame |=> !ch_frame);
endmodule

// File: rtl/bwc_deserializer.sv
`timescale 1ns/1ps
module bwc_deserializer
  import bwc_pkg::*;
#(
  parameter int LANE_W     = BWC_LANE_W,
  parameter int LINE_BEATS = BWC_LINE_BEATS,
  parameter int WORD_BEATS = BWC_WORD_BEATS,
  localparam int WORD_W    = LANE_W * WORD_BEATS,
  localparam int CNT_W     = $clog2(LINE_BEATS),
  localparam int SUB_W     = $clog2(WORD_BEATS),
  localparam int SEL_W     = CNT_W - SUB_W,
  localparam int ACC_W     = WORD_W - LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANE_W-1:0] in_data,
  input  logic              in_par,
  input  logic              in_frame,
  input  logic              in_valid,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid,
  output logic [SEL_W-1:0]  word_sel,
  output logic              par_err
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] slot;
  logic [SUB_W-1:0] sub;
  logic [ACC_W-1:0] acc;
  logic             last_of_word;

  // A frame strobe forces this byte to position zero of the burst
  assign slot         = in_frame ? '0 : cnt;
  assign sub          = slot[SUB_W-1:0];
  assign last_of_word = (sub == SUB_W'(WORD_BEATS - 1));

  // One holding register per byte position below the top of the word
  for (genvar g = 0; g < WORD_BEATS - 1; g++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst) lane_q <= '0;
      else if (in_valid && sub == SUB_W'(g)) lane_q <= in_data;
    end
    assign acc[g*LANE_W +: LANE_W] = lane_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      word_data  <= '0;
      word_valid <= 1'b0;
      word_sel   <= '0;
      par_err    <= 1'b0;
    end else if (in_valid) begin
      cnt <= slot + CNT_W'(1);
      if (last_of_word) begin
        word_data  <= {in_data, acc};
        word_valid <= 1'b1;
        word_sel   <= slot[CNT_W-1:SUB_W];
      end else begin
        word_valid <= 1'b0;
      end
      if ((^in_data) != in_par) par_err <= 1'b1;
    end else begin
      word_valid <= 1'b0;
    end
  end

  // A word needs several accepted bytes, so pulses never touch
  assert_word_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  assert_err_raise_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ((^in_data) != in_par)) |=> par_err);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    par_err |=> par_err);

  // Idle beats leave the flag untouched
  assert_idle_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !par_err) |=> !par_err);
endmodule

// File: rtl/burst_width_conv.sv
`timescale 1ns/1ps
module burst_width_conv
  import bwc_pkg::*;
#(
  parameter int LANE_W     = BWC_LANE_W,
  parameter int LINE_BEATS = BWC_LINE_BEATS,
  parameter int WORD_BEATS = BWC_WORD_BEATS,
  localparam int LINE_W    = LANE_W * LINE_BEATS,
  localparam int WORD_W    = LANE_W * WORD_BEATS,
  localparam int SEL_W     = $clog2(LINE_BEATS) - $clog2(WORD_BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_line_valid,
  input  logic [LINE_W-1:0] tx_line_data,
  output logic              tx_line_ready,
  output logic [LANE_W-1:0] ch_tx_data,
  output logic              ch_tx_par,
  output logic              ch_tx_frame,
  output logic              ch_tx_valid,
  input  logic [LANE_W-1:0] ch_rx_data,
  input  logic              ch_rx_par,
  input  logic              ch_rx_frame,
  input  logic              ch_rx_valid,
  output logic [WORD_W-1:0] rx_word_data,
  output logic              rx_word_valid,
  output logic [SEL_W-1:0]  rx_word_sel,
  output logic              rx_par_err
);
  bwc_serializer #(
    .LANE_W     (LANE_W),
    .LINE_BEATS (LINE_BEATS)
  ) u_tx (
    .clk        (clk),
    .rst        (rst),
    .line_valid (tx_line_valid),
    .line_data  (tx_line_data),
    .line_ready (tx_line_ready),
    .ch_data    (ch_tx_data),
    .ch_par     (ch_tx_par),
    .ch_frame   (ch_tx_frame),
    .ch_valid   (ch_tx_valid)
  );

  bwc_deserializer #(
    .LANE_W     (LANE_W),
    .LINE_BEATS (LINE_BEATS),
    .WORD_BEATS (WORD_BEATS)
  ) u_rx (
    .clk        (clk),
    .rst        (rst),
    .in_data    (ch_rx_data),
    .in_par     (ch_rx_par),
    .in_frame   (ch_rx_frame),
    .in_valid   (ch_rx_valid),
    .word_data  (rx_word_data),
    .word_valid (rx_word_valid),
    .word_sel   (rx_word_sel),
    .par_err    (rx_par_err)
  );
endmodule

// File: tb/tb_burst_width_conv.sv
`timescale 1ns/1ps
module tb_burst_width_conv;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_line_valid = 1'b0;
  logic [63:0] tx_line_data = '0;
  logic        tx_line_ready;
  logic [7:0]  ch_tx_data;
  logic        ch_tx_par, ch_tx_frame, ch_tx_valid;
  logic [7:0]  ch_rx_data = '0;
  logic        ch_rx_par = 1'b0, ch_rx_frame = 1'b0, ch_rx_valid = 1'b0;
  logic [31:0] rx_word_data;
  logic        rx_word_valid;
  logic [0:0]  rx_word_sel;
  logic        rx_par_err;

  always #2 clk = ~clk;

  burst_width_conv dut (
    .clk(clk), .rst(rst),
    .tx_line_valid(tx_line_valid), .tx_line_data(tx_line_data), .tx_line_ready(tx_line_ready),
    .ch_tx_data(ch_tx_data), .ch_tx_par(ch_tx_par), .ch_tx_frame(ch_tx_frame), .ch_tx_valid(ch_tx_valid),
    .ch_rx_data(ch_rx_data), .ch_rx_par(ch_rx_par), .ch_rx_frame(ch_rx_frame), .ch_rx_valid(ch_rx_valid),
    .rx_word_data(rx_word_data), .rx_word_valid(rx_word_valid), .rx_word_sel(rx_word_sel),
    .rx_par_err(rx_par_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  string cur_tag = "R5";

  // Receive-side model of what the ports should show after the next edge
  logic        exp_valid, exp_err;
  logic [31:0] exp_word;
  logic        exp_sel;
  int          mcnt;
  logic [7:0]  macc [4];

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic even_par(input logic [7:0] b);
    return ^b;
  endfunction

  task automatic model_clear();
    exp_valid = 1'b0; exp_err = 1'b0; exp_word = '0; exp_sel = 1'b0; mcnt = 0;
    for (int i = 0; i < 4; i++) macc[i] = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1; tx_line_valid = 1'b0; ch_rx_valid = 1'b0; ch_rx_frame = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
    chk(tx_line_ready == 1'b1, "R9 ready after reset", 64'(tx_line_ready), 64'd1);
    chk(ch_tx_valid == 1'b0, "R9 tx valid after reset", 64'(ch_tx_valid), 64'd0);
    chk(ch_tx_frame == 1'b0, "R9 tx frame after reset", 64'(ch_tx_frame), 64'd0);
    chk(rx_word_valid == 1'b0, "R9 word valid after reset", 64'(rx_word_valid), 64'd0);
    chk(rx_par_err == 1'b0, "R9 parity flag after reset", 64'(rx_par_err), 64'd0);
  endtask

  // Starts and ends at a falling edge; offers nxt mid-burst when preview is set
  task automatic tx_burst(input logic [63:0] line, input bit preview, input logic [63:0] nxt);
    chk(tx_line_ready == 1'b1, "R4 ready before offer", 64'(tx_line_ready), 64'd1);
    tx_line_valid = 1'b1;
    tx_line_data  = line;
    @(posedge clk);
    for (int k = 0; k < 8; k++) begin
      logic [7:0] b;
      b = line[k*8 +: 8];
      @(negedge clk);
      if (k == 0) tx_line_valid = 1'b0;
      chk(ch_tx_data == b, "R1 byte order", 64'(ch_tx_data), 64'(b));
      chk(ch_tx_par == even_par(b), "R2 even parity", 64'(ch_tx_par), 64'(even_par(b)));
      chk(ch_tx_frame == (k == 0), "R3 frame strobe", 64'(ch_tx_frame), 64'(k == 0));
      chk(ch_tx_valid == 1'b1, "R3 valid in burst", 64'(ch_tx_valid), 64'd1);
      chk(tx_line_ready == (k == 7), "R4 ready timing", 64'(tx_line_ready), 64'(k == 7));
      if (preview && k == 2) begin
        tx_line_valid = 1'b1;
        tx_line_data  = nxt;
      end
    end
  endtask

  task automatic tx_idle();
    @(negedge clk);
    chk(ch_tx_valid == 1'b0, "R3 valid low when idle", 64'(ch_tx_valid), 64'd0);
    chk(ch_tx_frame == 1'b0, "R3 frame low when idle", 64'(ch_tx_frame), 64'd0);
    chk(tx_line_ready == 1'b1, "R4 ready when idle", 64'(tx_line_ready), 64'd1);
  endtask

  task automatic rx_beat(input logic [7:0] d, input logic p, input logic f, input logic v);
    int slot;
    @(negedge clk);
    chk(rx_word_valid === exp_valid, {cur_tag, " word pulse"}, 64'(rx_word_valid), 64'(exp_valid));
    if (exp_valid) begin
      chk(rx_word_data === exp_word, {cur_tag, " word data"}, 64'(rx_word_data), 64'(exp_word));
      chk(rx_word_sel === exp_sel, "R6 half select", 64'(rx_word_sel), 64'(exp_sel));
    end
    chk(rx_par_err === exp_err, {cur_tag, " R8 parity flag"}, 64'(rx_par_err), 64'(exp_err));
    ch_rx_data = d; ch_rx_par = p; ch_rx_frame = f; ch_rx_valid = v;
    if (v) begin
      slot = f ? 0 : mcnt;
      macc[slot % 4] = d;
      if (slot % 4 == 3) begin
        exp_valid = 1'b1;
        exp_word  = {d, macc[2], macc[1], macc[0]};
        exp_sel   = (slot / 4) != 0;
      end else begin
        exp_valid = 1'b0;
      end
      mcnt = (slot + 1) % 8;
      if (even_par(d) != p) exp_err = 1'b1;
    end else begin
      exp_valid = 1'b0;
    end
  endtask

  task automatic rx_burst(input logic [63:0] line, input bit gaps);
    for (int k = 0; k < 8; k++) begin
      logic [7:0] b;
      b = line[k*8 +: 8];
      if (gaps && ($urandom % 3 == 0))
        rx_beat(8'($urandom), 1'($urandom), 1'($urandom), 1'b0);
      rx_beat(b, even_par(b), k == 0, 1'b1);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();

    // Transmit path: directed patterns
    tx_burst(64'h0807_0605_0403_0201, 1'b0, '0);
    tx_idle();
    tx_burst(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, '0);
    tx_burst(64'h0000_0000_0000_0000, 1'b0, '0);   // back to back with the one above
    tx_burst(64'h8001_4002_2004_1008, 1'b0, '0);
    tx_idle();
    // Offer during a burst is held off and sent next, intact
    tx_burst(64'hA5A5_5A5A_C3C3_3C3C, 1'b1, 64'h1122_3344_5566_7788);
    tx_burst(64'h1122_3344_5566_7788, 1'b0, '0);
    tx_idle();
    // Transmit path: random lines, random gaps
    for (int i = 0; i < 24; i++) begin
      logic [63:0] ln;
      ln = {$urandom, $urandom};
      tx_burst(ln, 1'b0, '0);
      if ($urandom % 2) tx_idle();
    end
    tx_idle();

    // Receive path: clean burst
    cur_tag = "R5";
    rx_burst(64'h8877_6655_4433_2211, 1'b0);
    rx_beat('0, 1'b0, 1'b0, 1'b0);
    // Idle beats with junk, bad parity and stray frame strobes
    cur_tag = "R10";
    for (int i = 0; i < 4; i++) rx_burst({$urandom, $urandom}, 1'b1);
    rx_beat(8'h01, 1'b0, 1'b1, 1'b0);
    rx_beat(8'h07, 1'b0, 1'b0, 1'b0);
    // Frame strobe in mid-word drops the partial bytes
    cur_tag = "R7";
    rx_beat(8'hDE, even_par(8'hDE), 1'b1, 1'b1);
    rx_beat(8'hAD, even_par(8'hAD), 1'b0, 1'b1);
    rx_burst(64'h0F1E_2D3C_4B5A_6978, 1'b0);
    for (int k = 0; k < 6; k++) rx_beat(8'(k + 1), even_par(8'(k + 1)), k == 0, 1'b1);
    rx_burst(64'hCAFE_F00D_BEEF_1234, 1'b1);
    rx_beat('0, 1'b0, 1'b0, 1'b0);
    // Random bursts
    cur_tag = "R5";
    for (int i = 0; i < 30; i++) rx_burst({$urandom, $urandom}, 1'($urandom));
    rx_beat('0, 1'b0, 1'b0, 1'b0);
    // Parity error on an accepted byte, then flag must hold
    cur_tag = "R8";
    rx_beat(8'h03, 1'b1, 1'b1, 1'b1);
    rx_burst(64'h0102_0304_0506_0708, 1'b1);
    rx_beat('0, 1'b0, 1'b0, 1'b0);
    rx_beat('0, 1'b0, 1'b0, 1'b0);
    do_reset();
    cur_tag = "R9";
    rx_beat('0, 1'b0, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule